// File: doc/BRIEF.md
# Three-Backplane LCD Segment Multiplexer

This block turns a display image into logic-level drive codes for a liquid crystal panel wired with three backplanes and twelve segment columns. The image holds four seven-segment digits, a half digit, a minus sign, four decimal points, a low-battery flag, a continuity flag and an overrange flag. Each column line carries three segments, one for each backplane time slot. The block steps through the three slots, chooses for every column the segment bit that belongs to the current slot, and flips the polarity of every output on alternate frames so that no segment sees a net DC level. It also provides an annunciator square wave at frame rate, locked to the backplanes.

The image inputs may change at any time. The block copies them into an internal frame image only on the clock edge that ends a frame, so each frame shows one consistent image. Each line is encoded as a two-bit drive code, so the analog level generator after this block only has to map codes to voltages. When the overrange flag is set, the block blanks all four digits.

Top module: `lcdmux_tri`

## Requirements
- R1: While reset is held and until the first frame ends, backplane 1 is active, the frame polarity is even, the annunciator is 0, and every column carries the off code, whatever the image inputs are.
- R2: Each line carries a two-bit code: 2'b00 means non-selected (mid level), 2'b01 means low and 2'b10 means high. Exactly one backplane is active at a time. The slots run in the order backplane 1, 2, 3, and each lasts SLOT_CLKS clocks. The active backplane is high in even frames and low in odd frames. Inactive backplanes carry 2'b00. Backplane k uses bp_o[2k-1:2k-2].
- R3: The frame polarity toggles on the clock edge that moves from slot 3 back to slot 1, so every frame lasts 3*SLOT_CLKS clocks.
- R4: Column c uses seg_o[2c+1:2c], and digit d is 1 to 4. Column 3(d-1) carries B, C and then an extra bit. Column 3(d-1)+1 carries A, G and D. Column 3(d-1)+2 carries F, E and decimal point d. Each triple is listed in backplane order 1, 2, 3. The extra bits for digits 1 to 4 are, in order, continuity, low battery, minus and half digit.
- R5: A segment that is on is driven with the code opposite to the active backplane: low in even frames and high in odd frames. A segment that is off carries 2'b00.
- R6: The image inputs are sampled only on the clock edge that ends a frame. A change at any other time has no effect on the outputs until that edge.
- R7: The annunciator output is 1 throughout odd frames and 0 throughout even frames. It changes on the same edge as the polarity.
- R8: When the sampled overrange flag is 1, segments A to G of all four digits are off. The decimal points, minus sign, half digit and both flags are still shown.
- R9: digit_seg_i holds digit d in bits [7d-1:7d-7], with A at the lowest bit and then B, C, D, E, F, G. Decimal point d is dp_i[d-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_seg_i | input | 28 | Segments A..G of the four digits |
| dp_i | input | 4 | Decimal point enables |
| minus_i | input | 1 | Minus sign |
| half_i | input | 1 | Half digit (both segments) |
| lobat_i | input | 1 | Low-battery flag |
| cont_i | input | 1 | Continuity flag |
| ovr_i | input | 1 | Overrange, blanks the digits |
| bp_o | output | 6 | Drive codes of backplanes 1..3 |
| seg_o | output | 24 | Drive codes of the twelve columns |
| ann_o | output | 1 | Annunciator square wave |

## Verification
The hardest case to reach is an image that changes in the middle of a frame, right up to the edge before the frame ends, while an overrange toggles at the same moment. Only the frame-end sample may show, and a wrong sample point is off by just one clock. The random phase changes fields on about a quarter of all cycles, so edits land in every slot position, including the last clock of a frame. The bench model latches its own copy only on edges that close a frame. Directed phases show an all-on image with overrange clear and then set, which covers every column triple in both polarities.

// File: rtl/lcdmux_pkg.sv
`timescale 1ns/1ps
package lcdmux_pkg;
   localparam int NUM_DIG     = 4;
   localparam int SEG_PER_DIG = 7;
   localparam int NUM_BP      = 3;
   localparam int COL_PER_DIG = 3;
   localparam int NUM_COL     = NUM_DIG * COL_PER_DIG;

   localparam int SEG_A = 0;
   localparam int SEG_B = 1;
   localparam int SEG_C = 2;
   localparam int SEG_D = 3;
   localparam int SEG_E = 4;
   localparam int SEG_F = 5;
   localparam int SEG_G = 6;

   typedef enum logic [1:0] {
      DRV_MID = 2'b00,
      DRV_LO  = 2'b01,
      DRV_HI  = 2'b10
   } drv_e;

   typedef struct packed {
      logic                           ovr;
      logic [NUM_DIG-1:0]             extra;
      logic [NUM_DIG-1:0]             dp;
      logic [NUM_DIG*SEG_PER_DIG-1:0] seg;
   } image_t;

   // backplane: high in even frames when selected
   function automatic logic [1:0] bp_code(input logic act, input logic pol);
      if (!act) return DRV_MID;
      return pol ? DRV_LO : DRV_HI;
   endfunction

   // segment: opposite of the active backplane when on
   function automatic logic [1:0] seg_code(input logic on, input logic pol);
      if (!on) return DRV_MID;
      return pol ? DRV_HI : DRV_LO;
   endfunction
endpackage

// File: rtl/lcdmux_timing.sv
`timescale 1ns/1ps
module lcdmux_timing #(
   parameter int SLOT_CLKS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [1:0] slot_o,
   output logic       pol_o,
   output logic       frame_end_o
);
   localparam int DIV_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOT_CLKS - 1);

   initial begin
      assert (SLOT_CLKS >= 2) else $error("SLOT_CLKS must be at least 2");
   end

   logic [DIV_W-1:0] div_q;
   logic [1:0]       slot_q;
   logic             pol_q;
   logic             slot_end;

   assign slot_end    = (div_q == DIV_LAST);
   assign frame_end_o = slot_end && (slot_q == 2'd2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         slot_q <= 2'd0;
         pol_q  <= 1'b0;
      end else begin
         div_q <= slot_end ? '0 : div_q + 1'b1;
         if (slot_end) slot_q <= (slot_q == 2'd2) ? 2'd0 : slot_q + 2'd1;
         if (frame_end_o) pol_q <= ~pol_q;
      end
   end

   assign slot_o = slot_q;
   assign pol_o  = pol_q;
endmodule

// File: rtl/lcdmux_image.sv
`timescale 1ns/1ps
module lcdmux_image
   import lcdmux_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   frame_end_i,
   input  image_t raw_i,
   output image_t img_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)           img_o <= '0;
      else if (frame_end_i) img_o <= raw_i;
   end
endmodule

// File: rtl/lcdmux_colmap.sv
`timescale 1ns/1ps
module lcdmux_colmap
   import lcdmux_pkg::*;
(
   input  image_t               img_i,
   input  logic [1:0]           slot_i,
   input  logic                 pol_i,
   output logic [2*NUM_COL-1:0] seg_o
);
   function automatic logic pick(input logic [2:0] v, input logic [1:0] sl);
      case (sl)
         2'd0:    return v[0];
         2'd1:    return v[1];
         2'd2:    return v[2];
         default: return 1'b0;
      endcase
   endfunction

   for (genvar d = 0; d < NUM_DIG; d++) begin : g_dig
      localparam int C0 = d * COL_PER_DIG;
      logic [SEG_PER_DIG-1:0] s;
      logic [2:0] v_bc, v_agd, v_fe;

      assign s     = img_i.ovr ? '0 : img_i.seg[d*SEG_PER_DIG +: SEG_PER_DIG];
      // bit index equals backplane slot
      assign v_bc  = {img_i.extra[d], s[SEG_C], s[SEG_B]};
      assign v_agd = {s[SEG_D], s[SEG_G], s[SEG_A]};
      assign v_fe  = {img_i.dp[d], s[SEG_E], s[SEG_F]};

      assign seg_o[2*C0     +: 2] = seg_code(pick(v_bc,  slot_i), pol_i);
      assign seg_o[2*(C0+1) +: 2] = seg_code(pick(v_agd, slot_i), pol_i);
      assign seg_o[2*(C0+2) +: 2] = seg_code(pick(v_fe,  slot_i), pol_i);
   end
endmodule

// File: rtl/lcdmux_tri.sv
`timescale 1ns/1ps
module lcdmux_tri
   import lcdmux_pkg::*;
#(
   parameter int SLOT_CLKS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_DIG*SEG_PER_DIG-1:0] digit_seg_i,
   input  logic [NUM_DIG-1:0]             dp_i,
   input  logic                           minus_i,
   input  logic                           half_i,
   input  logic                           lobat_i,
   input  logic                           cont_i,
   input  logic                           ovr_i,
   output logic [2*NUM_BP-1:0]            bp_o,
   output logic [2*NUM_COL-1:0]           seg_o,
   output logic                           ann_o
);
   logic [1:0] slot_q;
   logic       pol_q;
   logic       frame_end;
   image_t     raw;
   image_t     img_q;

   assign raw.seg   = digit_seg_i;
   assign raw.dp    = dp_i;
   assign raw.extra = {half_i, minus_i, lobat_i, cont_i};
   assign raw.ovr   = ovr_i;

   lcdmux_timing #(.SLOT_CLKS(SLOT_CLKS)) i_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_o      (slot_q),
      .pol_o       (pol_q),
      .frame_end_o (frame_end)
   );

   lcdmux_image i_image (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_end_i (frame_end),
      .raw_i       (raw),
      .img_o       (img_q)
   );

   lcdmux_colmap i_colmap (
      .img_i  (img_q),
      .slot_i (slot_q),
      .pol_i  (pol_q),
      .seg_o  (seg_o)
   );

   for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
      assign bp_o[2*b +: 2] = bp_code(slot_q == 2'(b), pol_q);
   end

   assign ann_o = pol_q;
endmodule

// File: rtl/lcdmux_tri_chk.sv
`timescale 1ns/1ps
module lcdmux_tri_chk
   import lcdmux_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic [2*NUM_BP-1:0]  bp_o,
   input logic [2*NUM_COL-1:0] seg_o,
   input logic                 ann_o,
   input logic [1:0]           slot,
   input logic                 frame_end,
   input image_t               img
);
   logic [NUM_BP-1:0] act;
   logic [1:0]        act_code;
   logic              clash;
   logic              digit_lit;

   always_comb begin
      act      = '0;
      act_code = DRV_MID;
      for (int b = 0; b < NUM_BP; b++) begin
         act[b] = (bp_o[2*b +: 2] != DRV_MID);
         if (act[b]) act_code = bp_o[2*b +: 2];
      end
      clash     = 1'b0;
      digit_lit = 1'b0;
      for (int c = 0; c < NUM_COL; c++) begin
         if (seg_o[2*c +: 2] != DRV_MID && seg_o[2*c +: 2] == act_code) clash = 1'b1;
         if ((c % COL_PER_DIG) == 1 && seg_o[2*c +: 2] != DRV_MID) digit_lit = 1'b1;
      end
   end

   // R2
   one_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(act) == 1);

   // R3
   pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == 2'd0 && $past(slot) == 2'd2) |-> (ann_o != $past(ann_o)));

   // R7
   ann_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == $past(slot)) |-> $stable(ann_o));

   // R7
   ann_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_code == (ann_o ? DRV_LO : DRV_HI));

   // R5
   seg_opp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clash);

   // R6
   img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_end) |-> $stable(img));

   // R8
   blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (img.ovr && slot != 2'd2) |-> !digit_lit);
endmodule

bind lcdmux_tri lcdmux_tri_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bp_o      (bp_o),
   .seg_o     (seg_o),
   .ann_o     (ann_o),
   .slot      (slot_q),
   .frame_end (frame_end),
   .img       (img_q)
);

// File: tb/test_lcdmux_tri.sv
`timescale 1ns/1ps
module test_lcdmux_tri;
   localparam int S = 8;
   localparam int F = 3 * S;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [27:0] dseg;
   logic [3:0]  dp;
   logic        minus, half, lobat, cont, ovr;
   logic [5:0]  bp_o;
   logic [23:0] seg_o;
   logic        ann_o;

   int checks = 0;
   int errors = 0;
   int n = 0;
   bit done = 0;

   logic [27:0] m_seg;
   logic [3:0]  m_dp;
   logic [3:0]  m_extra;
   logic        m_ovr;

   always #4 clk = ~clk;

   lcdmux_tri #(.SLOT_CLKS(S)) i_lcdmux_tri (
      .clk(clk), .rst_n(rst_n), .digit_seg_i(dseg), .dp_i(dp),
      .minus_i(minus), .half_i(half), .lobat_i(lobat), .cont_i(cont),
      .ovr_i(ovr), .bp_o(bp_o), .seg_o(seg_o), .ann_o(ann_o)
   );

   function automatic logic [1:0] exp_code(input bit on, input bit p, input bit is_bp);
      if (!on) return 2'b00;
      return (p ^ is_bp) ? 2'b10 : 2'b01;
   endfunction

   // column map from R4, digit bit order from R9, blanking from R8
   function automatic bit exp_bit(input int c, input int s);
      int d = c / 3;
      logic [6:0] g = m_ovr ? 7'd0 : m_seg[7*d +: 7];
      case (c % 3)
         0:       return (s == 0) ? g[1] : (s == 1) ? g[2] : m_extra[d];
         1:       return (s == 0) ? g[0] : (s == 1) ? g[6] : g[3];
         default: return (s == 0) ? g[5] : (s == 1) ? g[4] : m_dp[d];
      endcase
   endfunction

   task automatic check_outputs();
      int s = (n / S) % 3;
      bit p = ((n / F) % 2) == 1;
      logic [5:0]  eb;
      logic [23:0] es;
      for (int b = 0; b < 3; b++) eb[2*b +: 2] = exp_code(b == s, p, 1'b1);
      for (int c = 0; c < 12; c++) es[2*c +: 2] = exp_code(exp_bit(c, s), p, 1'b0);
      checks++;
      if (bp_o !== eb) begin
         errors++;
         $display("FAIL R2 R3 bp_o cycle %0d got %h exp %h", n, bp_o, eb);
      end
      checks++;
      if (seg_o !== es) begin
         errors++;
         $display("FAIL R4 R5 R6 R8 R9 seg_o cycle %0d got %h exp %h", n, seg_o, es);
      end
      checks++;
      if (ann_o !== p) begin
         errors++;
         $display("FAIL R7 ann_o cycle %0d got %b exp %b", n, ann_o, p);
      end
   endtask

   task automatic step();
      @(posedge clk);
      n++;
      if (n % F == 0) begin
         m_seg = dseg; m_dp = dp; m_extra = {half, minus, lobat, cont}; m_ovr = ovr;
      end
      @(negedge clk);
      check_outputs();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      void'($urandom(32'd7129));
      rst_n = 1'b0;
      dseg = $urandom(); dp = 4'hf; minus = 1; half = 1; lobat = 1; cont = 1; ovr = 0;
      m_seg = '0; m_dp = '0; m_extra = '0; m_ovr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, image inputs not yet shown
      checks++;
      if (bp_o !== 6'b000010 || seg_o !== 24'd0 || ann_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset got bp %h seg %h ann %b exp bp 02 seg 000000 ann 0",
                  bp_o, seg_o, ann_o);
      end
      repeat (2 * F) step();
      // every segment lit, overrange clear then set (R4 R8)
      dseg = '1; dp = 4'hf; {minus, half, lobat, cont} = 4'hf; ovr = 0;
      repeat (2 * F) step();
      ovr = 1;
      repeat (2 * F) step();
      dp = 4'b0101; minus = 0; cont = 0;
      repeat (2 * F) step();
      // random edits in all slot positions (R6)
      for (int i = 0; i < 40 * F; i++) begin
         step();
         if (($urandom() % 4) == 0) begin
            dseg = $urandom(); dp = $urandom();
            {minus, half, lobat, cont} = $urandom();
            ovr = (($urandom() % 5) == 0);
         end
      end
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end
endmodule